// File: doc/BRIEF.md
# I2C-to-SPI Bridge Command Front End

This block is the I2C target side of a bridge that turns each I2C write into one complete, chip-select-framed SPI burst. A host addresses the bridge and sends a function byte. A chip-select mask function stores the bytes that follow in a shared byte buffer. At the STOP condition the block hands the byte count and the mask to an SPI engine, which sits outside this block. The engine shifts each stored byte out and writes the byte it captured on MISO back into the same slot. The host then reads the buffer back over I2C. A separate configuration function loads a single SPI setup byte and starts no burst.

The block recovers START, STOP and the bit edges from oversampled SCL/SDA, matches its 7-bit address, and drives ACK and read data on an open-drain SDA enable. It owns the buffer memory, which is written as a simple dual-port RAM. While a burst runs it refuses its own address, so the host polls until the bridge acknowledges again.

Top module: `i2cspi_bridge`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA pulled low in the ninth clock) when no burst is running. Any other address is not acknowledged and has no effect.
- R2: From the cycle `xfer_start_o` pulses until `xfer_done_i` is seen, `busy_o` is high and the own address is not acknowledged. After the done pulse it is acknowledged again.
- R3: A function byte whose bits above NUM_CS-1 are zero and whose low NUM_CS bits are not all zero is a chip-select mask. The data bytes after it are stored at buffer index 0, 1, 2 and so on. At STOP, `xfer_start_o` pulses for one cycle with `xfer_len_o` equal to the stored count and `cs_sel_o` equal to the mask.
- R4: Function byte 0xF0 loads the next byte into `cfg_o` and acknowledges it. Any further bytes are not acknowledged. No burst starts.
- R5: Any other function byte (for example 0x00, 0x10, 0x30) is acknowledged. The data bytes after it are not acknowledged, the buffer is not written, and no burst starts.
- R6: At most DEPTH (200) data bytes are stored. Data byte DEPTH+1 and any later bytes are not acknowledged and are discarded. The burst then runs with `xfer_len_o` = DEPTH.
- R7: An I2C read returns the buffer from index 0 upward. Byte i is the byte the engine wrote into slot i, which is the MISO byte captured while data byte i was shifted out. The function byte is not counted.
- R8: Reading does not alter the buffer: a second read returns the same bytes.
- R9: Engine writes to the buffer (`eng_we_i`) take effect only while `busy_o` is high. At other times they do not change what a read returns.
- R10: A chip-select mask write with no data bytes starts no burst.
- R11: After reset, SDA is released, `busy_o` and `xfer_start_o` are low, and `cfg_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the I2C lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| xfer_start_o | output | 1 | One-cycle request to the SPI engine |
| xfer_len_o | output | CW | Number of bytes in the burst |
| cs_sel_o | output | NUM_CS | Chip-select mask for the burst |
| cfg_o | output | 8 | SPI configuration byte |
| busy_o | output | 1 | Burst in progress |
| xfer_done_i | input | 1 | One-cycle completion from the SPI engine |
| eng_addr_i | input | AW | Engine buffer index (read and write) |
| eng_wdata_i | input | 8 | MISO byte from the engine |
| eng_we_i | input | 1 | Engine buffer write strobe |
| eng_rdata_o | output | 8 | Buffer byte, one cycle after the address |

## Verification
The bench aims at the buffer limit: 203 bytes are sent after a mask. A design that miscounts would acknowledge byte 201, wrap into slot 0, or hand the engine a length of 0 or 201. It polls the address right after a STOP that launched a burst, where a design that ignores the busy state would acknowledge mid-burst. Function bytes that are neither the configuration code nor a legal mask, and a mask with no data, are sent to catch a design that writes the buffer or starts a burst anyway. Random masks and lengths, with a read back of the engine-altered bytes, expose index slips between the write and read paths and a read that modifies its own contents.

// File: rtl/i2cspi_pkg.sv
package i2cspi_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK0,
    S_ACK1,
    S_TX,
    S_MACK
  } pstate_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_FUNC,
    PH_DATA
  } phase_t;

  localparam logic [7:0] FUNC_CFG = 8'hF0;

endpackage

// File: rtl/i2cspi_linesync.sv
module i2cspi_linesync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cspi_buf.sv
module i2cspi_buf #(
  parameter int DEPTH = 200,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R6: no store lands outside the buffer
  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < AW'(DEPTH)));

endmodule

// File: rtl/i2cspi_proto.sv
module i2cspi_proto
  import i2cspi_pkg::*;
#(
  parameter int         DEPTH    = 200,
  parameter int         NUM_CS   = 4,
  parameter logic [6:0] DEV_ADDR = 7'h28,
  parameter int         AW       = 8,
  parameter int         CW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              xfer_done_i,
  input  logic [7:0]        rdata_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [AW-1:0]     rd_ptr_o,
  output logic              busy_o,
  output logic              xfer_start_o,
  output logic [CW-1:0]     xfer_len_o,
  output logic [NUM_CS-1:0] cs_sel_o,
  output logic [7:0]        cfg_o
);

  pstate_t       state;
  phase_t        phase;
  logic [7:0]    shreg;
  logic [2:0]    bitcnt;
  logic          ack_r;
  logic          mack_r;
  logic          is_read;
  logic [7:0]    func_r;
  logic          launch_ok;
  logic          cfg_taken;
  logic [CW-1:0] wcount;

  logic [7:0] nb;
  logic       nb_cs_ok;
  logic       fn_cs_ok;

  assign nb       = {shreg[6:0], sda_s};
  assign nb_cs_ok = ((nb >> NUM_CS) == 8'd0) && (nb[NUM_CS-1:0] != '0);
  assign fn_cs_ok = ((func_r >> NUM_CS) == 8'd0) && (func_r[NUM_CS-1:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      phase        <= PH_ADDR;
      shreg        <= 8'd0;
      bitcnt       <= 3'd0;
      ack_r        <= 1'b0;
      mack_r       <= 1'b0;
      is_read      <= 1'b0;
      func_r       <= 8'd0;
      launch_ok    <= 1'b0;
      cfg_taken    <= 1'b0;
      wcount       <= '0;
      sda_oe_o     <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= 8'd0;
      rd_ptr_o     <= '0;
      busy_o       <= 1'b0;
      xfer_start_o <= 1'b0;
      xfer_len_o   <= '0;
      cs_sel_o     <= '0;
      cfg_o        <= 8'd0;
    end else begin
      wr_en_o      <= 1'b0;
      xfer_start_o <= 1'b0;
      if (xfer_done_i) busy_o <= 1'b0;

      if (start_det) begin
        state     <= S_RX;
        phase     <= PH_ADDR;
        bitcnt    <= 3'd0;
        sda_oe_o  <= 1'b0;
        rd_ptr_o  <= '0;
        launch_ok <= 1'b0;
      end else if (stop_det) begin
        state     <= S_IDLE;
        sda_oe_o  <= 1'b0;
        launch_ok <= 1'b0;
        if (launch_ok && wcount != '0) begin
          xfer_start_o <= 1'b1;
          busy_o       <= 1'b1;
          xfer_len_o   <= wcount;
          cs_sel_o     <= func_r[NUM_CS-1:0];
        end
      end else begin
        unique case (state)
          S_RX: if (scl_rise) begin
            shreg  <= nb;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              state <= S_ACK0;
              ack_r <= 1'b0;
              unique case (phase)
                PH_ADDR: if (nb[7:1] == DEV_ADDR && !busy_o) begin
                  ack_r   <= 1'b1;
                  is_read <= nb[0];
                  if (!nb[0]) begin
                    wcount    <= '0;
                    cfg_taken <= 1'b0;
                  end
                end
                PH_FUNC: begin
                  ack_r     <= 1'b1;
                  func_r    <= nb;
                  launch_ok <= nb_cs_ok;
                end
                default: begin
                  if (func_r == FUNC_CFG) begin
                    if (!cfg_taken) begin
                      cfg_o     <= nb;
                      cfg_taken <= 1'b1;
                      ack_r     <= 1'b1;
                    end
                  end else if (fn_cs_ok && wcount < CW'(DEPTH)) begin
                    wr_en_o   <= 1'b1;
                    wr_addr_o <= wcount[AW-1:0];
                    wr_data_o <= nb;
                    wcount    <= wcount + CW'(1);
                    ack_r     <= 1'b1;
                  end
                end
              endcase
            end
          end
          S_ACK0: if (scl_fall) begin
            if (ack_r) begin
              sda_oe_o <= 1'b1;
              state    <= S_ACK1;
            end else begin
              state <= S_IDLE;
            end
          end
          S_ACK1: if (scl_fall) begin
            bitcnt <= 3'd0;
            phase  <= (phase == PH_ADDR) ? PH_FUNC : PH_DATA;
            if (phase == PH_ADDR && is_read) begin
              shreg    <= rdata_i;
              sda_oe_o <= ~rdata_i[7];
              state    <= S_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              state    <= S_MACK;
            end else begin
              sda_oe_o <= ~shreg[6];
              shreg    <= {shreg[6:0], 1'b0};
              bitcnt   <= bitcnt + 3'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_r <= ~sda_s;
              if (!sda_s && rd_ptr_o != AW'(DEPTH - 1))
                rd_ptr_o <= rd_ptr_o + AW'(1);
            end
            if (scl_fall) begin
              if (mack_r) begin
                shreg    <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
                bitcnt   <= 3'd0;
                state    <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: stored count never passes the buffer size
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    wcount <= CW'(DEPTH));

  // R2: the address is never acknowledged during a burst
  p_addr_refused_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK1 && phase == PH_ADDR) |-> !busy_o);

  // R3: a launch always carries data and a selected line
  p_launch_fields_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |-> (xfer_len_o != '0 && cs_sel_o != '0));

  // R9: busy accompanies every launch
  p_busy_with_start_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |-> busy_o);

  // R4: configuration moves only on a configuration data byte
  p_cfg_source_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(phase == PH_DATA && func_r == FUNC_CFG));

  // R10: STOP with nothing stored launches nothing
  p_no_empty_burst_r10: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wcount == '0) |=> !xfer_start_o);

  // R11: the line is released while idle
  p_idle_released_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe_o);

endmodule

// File: rtl/i2cspi_bridge.sv
module i2cspi_bridge #(
  parameter int         DEPTH    = 200,
  parameter int         NUM_CS   = 4,
  parameter logic [6:0] DEV_ADDR = 7'h28,
  localparam int        AW       = $clog2(DEPTH),
  localparam int        CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              xfer_start_o,
  output logic [CW-1:0]     xfer_len_o,
  output logic [NUM_CS-1:0] cs_sel_o,
  output logic [7:0]        cfg_o,
  output logic              busy_o,
  input  logic              xfer_done_i,
  input  logic [AW-1:0]     eng_addr_i,
  input  logic [7:0]        eng_wdata_i,
  input  logic              eng_we_i,
  output logic [7:0]        eng_rdata_o
);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          p_wr_en;
  logic [AW-1:0] p_wr_addr;
  logic [7:0]    p_wr_data;
  logic [AW-1:0] p_rd_ptr;
  logic          m_we;
  logic [AW-1:0] m_waddr, m_raddr;
  logic [7:0]    m_wdata, m_rdata;

  i2cspi_linesync u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2cspi_proto #(
    .DEPTH    (DEPTH),
    .NUM_CS   (NUM_CS),
    .DEV_ADDR (DEV_ADDR),
    .AW       (AW),
    .CW       (CW)
  ) u_proto (
    .clk          (clk),
    .rst          (rst),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .xfer_done_i  (xfer_done_i),
    .rdata_i      (m_rdata),
    .sda_oe_o     (sda_oe_o),
    .wr_en_o      (p_wr_en),
    .wr_addr_o    (p_wr_addr),
    .wr_data_o    (p_wr_data),
    .rd_ptr_o     (p_rd_ptr),
    .busy_o       (busy_o),
    .xfer_start_o (xfer_start_o),
    .xfer_len_o   (xfer_len_o),
    .cs_sel_o     (cs_sel_o),
    .cfg_o        (cfg_o)
  );

  // The engine owns the buffer only while a burst runs
  always_comb begin
    if (busy_o) begin
      m_we    = eng_we_i;
      m_waddr = eng_addr_i;
      m_wdata = eng_wdata_i;
      m_raddr = eng_addr_i;
    end else begin
      m_we    = p_wr_en;
      m_waddr = p_wr_addr;
      m_wdata = p_wr_data;
      m_raddr = p_rd_ptr;
    end
  end

  i2cspi_buf #(
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wdata),
    .raddr (m_raddr),
    .rdata (m_rdata)
  );

  assign eng_rdata_o = m_rdata;

endmodule

// File: tb/test_i2cspi_bridge.sv
module test_i2cspi_bridge;

  localparam int         DEPTH = 200;
  localparam int         NCS   = 4;
  localparam logic [6:0] DEV   = 7'h28;
  localparam int         AW    = $clog2(DEPTH);
  localparam int         CW    = $clog2(DEPTH + 1);
  localparam int         Q     = 5;
  localparam int         ENG_DELAY = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, xfer_start, busy, xfer_done;
  logic [CW-1:0]  xfer_len;
  logic [NCS-1:0] cs_sel;
  logic [7:0]     cfg, eng_rdata;
  logic [AW-1:0]  eng_addr_e, eng_addr;
  logic [7:0]     eng_wdata_e, eng_wdata;
  logic           eng_we_e, poke_we, eng_we;

  int nchk = 0;
  int nerr = 0;
  int eng_starts = 0;
  int eng_len = 0;
  int eng_mask = 0;
  logic [7:0] eng_tx [256];
  logic [7:0] wbuf [256];
  logic [7:0] rbuf [256];
  logic [7:0] expv [256];

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign eng_addr  = poke_we ? '0 : eng_addr_e;
  assign eng_wdata = poke_we ? 8'h5A : eng_wdata_e;
  assign eng_we    = eng_we_e | poke_we;

  i2cspi_bridge #(.DEPTH(DEPTH), .NUM_CS(NCS), .DEV_ADDR(DEV)) i_i2cspi_bridge (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .xfer_start_o (xfer_start),
    .xfer_len_o   (xfer_len),
    .cs_sel_o     (cs_sel),
    .cfg_o        (cfg),
    .busy_o       (busy),
    .xfer_done_i  (xfer_done),
    .eng_addr_i   (eng_addr),
    .eng_wdata_i  (eng_wdata),
    .eng_we_i     (eng_we),
    .eng_rdata_o  (eng_rdata)
  );

  function automatic logic [7:0] miso_of(input logic [7:0] tx, input int i);
    return tx ^ 8'hA5 ^ 8'(i);
  endfunction

  function automatic logic [7:0] rand_mask();
    return 8'($urandom_range(1, (1 << NCS) - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[k] = sda_line;
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] fn, input int n,
                          output bit a_addr, output bit a_fn, output int nacked);
    bit a;
    nacked = 0; a_fn = 1'b0;
    i2c_start();
    wr_byte({DEV, 1'b0}, a_addr);
    if (a_addr) begin
      wr_byte(fn, a_fn);
      for (int i = 0; i < n; i++) begin
        wr_byte(wbuf[i], a);
        if (a) nacked++;
      end
    end
    i2c_stop();
  endtask

  task automatic do_read(input int n, output bit a_addr);
    i2c_start();
    wr_byte({DEV, 1'b1}, a_addr);
    if (a_addr) begin
      for (int i = 0; i < n; i++) rd_byte(i != n - 1, rbuf[i]);
    end
    i2c_stop();
  endtask

  task automatic wait_engine();
    tick(4);
    while (busy) @(negedge clk);
    tick(4);
  endtask

  // SPI engine model: reads each byte, returns a derived MISO byte
  initial begin
    eng_addr_e = '0; eng_wdata_e = 8'd0; eng_we_e = 1'b0; xfer_done = 1'b0;
    forever begin
      @(negedge clk);
      if (xfer_start) begin
        eng_starts++;
        eng_len  = int'(xfer_len);
        eng_mask = int'(cs_sel);
        for (int i = 0; i < eng_len; i++) begin
          eng_addr_e = AW'(i);
          tick(2);
          eng_tx[i]   = eng_rdata;
          eng_wdata_e = miso_of(eng_rdata, i);
          eng_we_e    = 1'b1;
          tick(1);
          eng_we_e    = 1'b0;
        end
        tick(ENG_DELAY);
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    bit a_addr, a_fn;
    int nack, st0, n, bad;
    logic [7:0] fn;
    poke_we = 1'b0;
    void'($urandom(32'd4242));
    tick(5);
    rst = 1'b0;
    tick(3);

    // R11: reset state
    chk(!sda_oe, "R11 sda released", sda_oe, 0);
    chk(!busy && !xfer_start, "R11 idle", {busy, xfer_start}, 0);
    chk(cfg == 8'h00, "R11 cfg", cfg, 0);

    // R1: foreign address refused
    i2c_start();
    wr_byte({7'h29, 1'b0}, a_addr);
    i2c_stop();
    chk(!a_addr, "R1 foreign address", a_addr, 0);

    // R4: configuration write
    st0 = eng_starts;
    wbuf[0] = 8'h2C; wbuf[1] = 8'h77;
    do_write(8'hF0, 2, a_addr, a_fn, nack);
    tick(10);
    chk(a_addr && a_fn, "R1 own address acked", {a_addr, a_fn}, 3);
    chk(nack == 1, "R4 cfg acks", nack, 1);
    chk(cfg == 8'h2C, "R4 cfg value", cfg, 8'h2C);
    chk(eng_starts == st0, "R4 no burst", eng_starts - st0, 0);

    // R3 R7 R8: random masked writes and read back
    for (int it = 0; it < 5; it++) begin
      n  = $urandom_range(1, 12);
      fn = rand_mask();
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      st0 = eng_starts;
      do_write(fn, n, a_addr, a_fn, nack);
      chk(nack == n, "R3 data acked", nack, n);
      if (it == 0) begin
        // R2: address refused right after launch
        i2c_start();
        wr_byte({DEV, 1'b1}, a_addr);
        i2c_stop();
        chk(!a_addr, "R2 busy refusal", a_addr, 0);
        chk(busy, "R2 busy high", busy, 1);
      end
      wait_engine();
      chk(eng_starts == st0 + 1, "R3 one burst", eng_starts - st0, 1);
      chk(eng_len == n, "R3 length", eng_len, n);
      chk(eng_mask == int'(fn[NCS-1:0]), "R3 mask", eng_mask, fn);
      bad = 0;
      for (int i = 0; i < n; i++) if (eng_tx[i] !== wbuf[i]) bad++;
      chk(bad == 0, "R3 stored bytes", bad, 0);
      for (int i = 0; i < n; i++) expv[i] = miso_of(wbuf[i], i);
      do_read(n, a_addr);
      chk(a_addr, "R2 acked after done", a_addr, 1);
      bad = 0;
      for (int i = 0; i < n; i++) if (rbuf[i] !== expv[i]) bad++;
      chk(bad == 0, "R7 read back", bad, 0);
      do_read(n, a_addr);
      bad = 0;
      for (int i = 0; i < n; i++) if (rbuf[i] !== expv[i]) bad++;
      chk(bad == 0, "R8 second read", bad, 0);
    end

    // R9: engine write while idle ignored
    poke_we = 1'b1; tick(1); poke_we = 1'b0; tick(2);
    do_read(1, a_addr);
    chk(rbuf[0] == expv[0], "R9 idle engine write", rbuf[0], expv[0]);

    // R5: invalid functions
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    for (int v = 0; v < 3; v++) begin
      fn = (v == 0) ? 8'h10 : (v == 1) ? 8'h00 : 8'h30;
      st0 = eng_starts;
      do_write(fn, 3, a_addr, a_fn, nack);
      tick(10);
      chk(a_fn, "R5 function acked", a_fn, 1);
      chk(nack == 0, "R5 data refused", nack, 0);
      chk(eng_starts == st0, "R5 no burst", eng_starts - st0, 0);
    end
    do_read(1, a_addr);
    chk(rbuf[0] == expv[0], "R5 buffer unchanged", rbuf[0], expv[0]);

    // R10: mask with no data
    st0 = eng_starts;
    do_write(8'h01, 0, a_addr, a_fn, nack);
    tick(10);
    chk(eng_starts == st0, "R10 no burst", eng_starts - st0, 0);

    // R6: overflow
    for (int i = 0; i < DEPTH + 3; i++) wbuf[i] = 8'($urandom());
    st0 = eng_starts;
    do_write(8'h08, DEPTH + 3, a_addr, a_fn, nack);
    chk(nack == DEPTH, "R6 acked count", nack, DEPTH);
    wait_engine();
    chk(eng_starts == st0 + 1, "R6 one burst", eng_starts - st0, 1);
    chk(eng_len == DEPTH, "R6 length", eng_len, DEPTH);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (eng_tx[i] !== wbuf[i]) bad++;
    chk(bad == 0, "R6 stored bytes", bad, 0);
    do_read(DEPTH, a_addr);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (rbuf[i] !== miso_of(wbuf[i], i)) bad++;
    chk(bad == 0, "R7 full read back", bad, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule